// File: doc/BRIEF.md
# Console Keyboard and Display Register Block

This block is a peripheral on a 16-bit word-addressed processor bus. It answers a fixed set of addresses in the top I/O page and gives software two byte channels. The keyboard channel receives characters from a device strobe. The display channel hands characters to a device that acknowledges them. Each channel has one ready flag, and that flag is the whole handshake. Software polls bit 15 of a status word, then reads or writes the paired data word. The access to the data word updates the flag as a side effect.

The keyboard ready flag goes high when a character is strobed in. It drops when software reads the keyboard data word. The display ready flag drops when software writes the display data word. It returns high when the device acknowledges the character. While a display character is waiting, the device sees it on `dsp_char` with `dsp_valid` high. Bus reads are combinational, so read data is valid in the same cycle as the address. Every side effect of an access takes place at the clock edge that ends the access.

Top module: `console_mmio`

## Requirements
- R1: After reset, the keyboard flag is 0 and the display flag is 1. So word 0xFE00 reads 0x0000, word 0xFE04 reads 0x8000, and `dsp_valid` is 0.
- R2: `bus_sel` is 1 exactly when `bus_addr` >= 0xFE00. Below that, reads return 0 and writes change nothing. Addresses in the page that are not one of the four registers read 0.
- R3: A cycle with `kbd_stb` high stores `kbd_char`. From the next cycle on, bit 15 of word 0xFE00 reads 1, and word 0xFE02 reads the character in bits [7:0] with bits [15:8] zero.
- R4: Reading word 0xFE02 clears the keyboard flag at the end of that cycle. Reading word 0xFE00 leaves the flag unchanged.
- R5: A strobe while the keyboard flag is already 1 replaces the stored character, and the flag stays 1.
- R6: Writes to 0xFE02 and to 0xFE00 have no effect on the keyboard flag or on the keyboard character.
- R7: A write to word 0xFE06 stores `bus_wdata[7:0]` on `dsp_char` and clears the display flag. From the next cycle, `dsp_valid` is 1 and word 0xFE04 reads 0x0000.
- R8: A cycle with `dsp_ack` high sets the display flag. From the next cycle, `dsp_valid` is 0 and word 0xFE04 reads 0x8000.
- R9: When a flag set and a flag clear fall in the same cycle, the set wins. A strobe together with a read of 0xFE02 leaves the keyboard flag at 1 and stores the new character. An acknowledge together with a write of 0xFE06 leaves the display flag at 1 and still stores the written character.
- R10: Bits [14:0] of both status words read 0. Word 0xFE06 reads 0.
- R11: `bus_rdata` is 0 whenever `bus_rd` is low. When `bus_rd` is high, `bus_rdata` reflects the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Word address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| bus_sel | output | 1 | Address falls in the I/O page |
| kbd_stb | input | 1 | Keyboard character strobe |
| kbd_char | input | 8 | Keyboard character |
| dsp_char | output | 8 | Display character |
| dsp_valid | output | 1 | Display character waiting for acknowledge |
| dsp_ack | input | 1 | Display has taken the character |

## Verification
Read data and `bus_sel` come from combinational logic. The bench therefore samples them one nanosecond after it drives the address, inside the same cycle. Every flag change, every stored character and `dsp_valid` are due one cycle after the stimulus: they become visible right after the clock edge that closes the access. The bench samples these just after that edge, before it drives the next cycle. The checks sweep all 256 character values on both channels, every address in the I/O page and a stride through the rest of the address space. The bench compares each result with a value it derives from the requirements alone.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA
  } reg_sel_e;
endpackage

// File: rtl/console_decode.sv
module console_decode
  import console_pkg::*;
#(
  parameter int unsigned      AW      = 16,
  parameter logic [AW-1:0]    BASE    = 16'hFE00,
  parameter logic [AW-1:0]    KS_OFF  = 16'h0000,
  parameter logic [AW-1:0]    KD_OFF  = 16'h0002,
  parameter logic [AW-1:0]    DS_OFF  = 16'h0004,
  parameter logic [AW-1:0]    DD_OFF  = 16'h0006
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output reg_sel_e      sel
);
  localparam logic [AW-1:0] KS_ADDR = BASE + KS_OFF;
  localparam logic [AW-1:0] KD_ADDR = BASE + KD_OFF;
  localparam logic [AW-1:0] DS_ADDR = BASE + DS_OFF;
  localparam logic [AW-1:0] DD_ADDR = BASE + DD_OFF;

  always_comb begin
    hit = (addr >= BASE);
    sel = SEL_NONE;
    if (hit) begin
      if      (addr == KS_ADDR) sel = SEL_KSTAT;
      else if (addr == KD_ADDR) sel = SEL_KDATA;
      else if (addr == DS_ADDR) sel = SEL_DSTAT;
      else if (addr == DD_ADDR) sel = SEL_DDATA;
      else                      sel = SEL_NONE;
    end
  end
endmodule

// File: rtl/console_kbd_chan.sv
module console_kbd_chan #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          stb,
  input  logic [CW-1:0] char_in,
  input  logic          clr,
  output logic          rdy,
  output logic [CW-1:0] chr
);
  logic          rdy_d;
  logic          chr_en;

  // the device-side set is applied last, so it overrides a clear in the same cycle
  always_comb begin
    rdy_d  = rdy;
    chr_en = stb;
    if (clr) rdy_d = 1'b0;
    if (stb) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdy <= 1'b0;
      chr <= '0;
    end else begin
      rdy <= rdy_d;
      if (chr_en) chr <= char_in;
    end
  end
endmodule

// File: rtl/console_dsp_chan.sv
module console_dsp_chan #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          wr,
  input  logic [CW-1:0] wchar,
  input  logic          ack,
  output logic          rdy,
  output logic [CW-1:0] chr
);
  logic rdy_d;
  logic chr_en;

  always_comb begin
    rdy_d  = rdy;
    chr_en = wr;
    if (wr)  rdy_d = 1'b0;
    if (ack) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdy <= 1'b1;
      chr <= '0;
    end else begin
      rdy <= rdy_d;
      if (chr_en) chr <= wchar;
    end
  end
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_pkg::*;
#(
  parameter int unsigned   AW     = 16,
  parameter int unsigned   DW     = 16,
  parameter int unsigned   CW     = 8,
  parameter logic [AW-1:0] BASE   = 16'hFE00,
  parameter logic [AW-1:0] KS_OFF = 16'h0000,
  parameter logic [AW-1:0] KD_OFF = 16'h0002,
  parameter logic [AW-1:0] DS_OFF = 16'h0004,
  parameter logic [AW-1:0] DD_OFF = 16'h0006
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_sel,
  input  logic          kbd_stb,
  input  logic [CW-1:0] kbd_char,
  output logic [CW-1:0] dsp_char,
  output logic          dsp_valid,
  input  logic          dsp_ack
);
  localparam int unsigned FLAG_BIT = DW - 1;
  localparam int unsigned SYNC_N   = 2;

  logic [SYNC_N-1:0] rst_q;
  logic              srst_n;
  reg_sel_e          sel;
  logic              kbd_clr;
  logic              dsp_wr;
  logic              kbd_rdy;
  logic              dsp_rdy;
  logic [CW-1:0]     kbd_chr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[SYNC_N-2:0], 1'b1};
  end
  assign srst_n = rst_q[SYNC_N-1];

  console_decode #(
    .AW(AW), .BASE(BASE), .KS_OFF(KS_OFF), .KD_OFF(KD_OFF),
    .DS_OFF(DS_OFF), .DD_OFF(DD_OFF)
  ) dec_i (
    .addr (bus_addr),
    .hit  (bus_sel),
    .sel  (sel)
  );

  assign kbd_clr = bus_rd && (sel == SEL_KDATA);
  assign dsp_wr  = bus_wr && (sel == SEL_DDATA);

  console_kbd_chan #(.CW(CW)) kbd_i (
    .clk     (clk),
    .srst_n  (srst_n),
    .stb     (kbd_stb),
    .char_in (kbd_char),
    .clr     (kbd_clr),
    .rdy     (kbd_rdy),
    .chr     (kbd_chr)
  );

  console_dsp_chan #(.CW(CW)) dsp_i (
    .clk    (clk),
    .srst_n (srst_n),
    .wr     (dsp_wr),
    .wchar  (bus_wdata[CW-1:0]),
    .ack    (dsp_ack),
    .rdy    (dsp_rdy),
    .chr    (dsp_char)
  );

  assign dsp_valid = !dsp_rdy;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_KSTAT: bus_rdata[FLAG_BIT] = kbd_rdy;
        SEL_KDATA: bus_rdata[CW-1:0]   = kbd_chr;
        SEL_DSTAT: bus_rdata[FLAG_BIT] = dsp_rdy;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
  parameter int unsigned   AW     = 16,
  parameter int unsigned   DW     = 16,
  parameter logic [AW-1:0] BASE   = 16'hFE00,
  parameter logic [AW-1:0] KS_OFF = 16'h0000,
  parameter logic [AW-1:0] KD_OFF = 16'h0002,
  parameter logic [AW-1:0] DD_OFF = 16'h0006
) (
  input logic          clk,
  input logic          srst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_sel,
  input logic          kbd_stb,
  input logic          dsp_ack,
  input logic          kbd_rdy,
  input logic          dsp_rdy
);
  localparam logic [AW-1:0] KS_ADDR = BASE + KS_OFF;
  localparam logic [AW-1:0] KD_ADDR = BASE + KD_OFF;
  localparam logic [AW-1:0] DD_ADDR = BASE + DD_OFF;

  a_r3_stb_sets: assert property (@(posedge clk) disable iff (!srst_n)
    kbd_stb |=> kbd_rdy);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && bus_addr == KD_ADDR && !kbd_stb) |=> !kbd_rdy);

  a_r6_kbd_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (!kbd_stb && !(bus_rd && bus_addr == KD_ADDR)) |=> $stable(kbd_rdy));

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == DD_ADDR && !dsp_ack) |=> !dsp_rdy);

  a_r8_ack_sets: assert property (@(posedge clk) disable iff (!srst_n)
    dsp_ack |=> dsp_rdy);

  a_r2_outside_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_addr < BASE) |-> (!bus_sel && bus_rdata == '0));

  a_r10_status_pad: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && bus_addr == KS_ADDR) |-> (bus_rdata[DW-2:0] == '0));

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

bind console_mmio console_mmio_chk #(
  .AW(AW), .DW(DW), .BASE(BASE), .KS_OFF(KS_OFF), .KD_OFF(KD_OFF), .DD_OFF(DD_OFF)
) chk_i (
  .clk       (clk),
  .srst_n    (srst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .bus_sel   (bus_sel),
  .kbd_stb   (kbd_stb),
  .dsp_ack   (dsp_ack),
  .kbd_rdy   (kbd_rdy),
  .dsp_rdy   (dsp_rdy)
);

// File: tb/console_mmio_tb_top.sv
`timescale 1ns/1ps
module console_mmio_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_sel;
  logic        kbd_stb;
  logic [7:0]  kbd_char;
  logic [7:0]  dsp_char;
  logic        dsp_valid;
  logic        dsp_ack;

  int n_cmp = 0;
  int n_bad = 0;
  logic        done = 1'b0;
  logic [15:0] rd_v;
  logic        sel_v;

  console_mmio dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_sel(bus_sel),
    .kbd_stb(kbd_stb), .kbd_char(kbd_char), .dsp_char(dsp_char),
    .dsp_valid(dsp_valid), .dsp_ack(dsp_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus/device cycle: comb outputs sampled mid-cycle into rd_v/sel_v,
  // registered effects visible on return (just after the closing edge)
  task automatic cyc(input logic [15:0] a, input logic rd, input logic wr,
                     input logic [15:0] wd, input logic stb, input logic [7:0] kc,
                     input logic ack);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    kbd_stb = stb; kbd_char = kc; dsp_ack = ack;
    #1;
    rd_v = bus_rdata; sel_v = bus_sel;
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0; kbd_stb = 1'b0; dsp_ack = 1'b0;
    bus_addr = 16'h0000; bus_wdata = 16'h0000; kbd_char = 8'h00;
  endtask

  task automatic rd(input logic [15:0] a);
    cyc(a, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0, 1'b0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    kbd_stb = 0; kbd_char = '0; dsp_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset values
    chk("R1 dsp_valid", {15'h0, dsp_valid}, 16'h0);
    rd(16'hFE00); chk("R1 kbd status", rd_v, 16'h0000);
    rd(16'hFE04); chk("R1 dsp status", rd_v, 16'h8000);

    // R2 outside page: no select, reads zero, writes ignored
    for (int a = 0; a < 'hFE00; a += 'h0101) begin
      rd(16'(a));
      chk("R2 outside sel", {15'h0, sel_v}, 16'h0);
      chk("R2 outside rdata", rd_v, 16'h0);
    end
    cyc(16'h0006, 1'b0, 1'b1, 16'h00AA, 1'b0, 8'h0, 1'b0);
    chk("R2 outside write", {15'h0, dsp_valid}, 16'h0);
    rd(16'hFE04); chk("R2 outside write flag", rd_v, 16'h8000);

    // R2 / R10 full page sweep (kbd flag 0, dsp flag 1)
    for (int a = 'hFE00; a <= 'hFFFF; a++) begin
      logic [15:0] e;
      e = (a == 'hFE04) ? 16'h8000 : 16'h0000;
      rd(16'(a));
      chk("R2 page sel", {15'h0, sel_v}, 16'h1);
      chk("R10 page rdata", rd_v, e);
    end

    // R3 / R5 / R4 sweep over all characters
    for (int c = 0; c < 256; c++) begin
      logic [7:0] c2;
      c2 = 8'(c) ^ 8'h5A;
      cyc(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 8'(c), 1'b0);
      rd(16'hFE00); chk("R3 flag set", rd_v, 16'h8000);
      rd(16'hFE00); chk("R4 status read keeps flag", rd_v, 16'h8000);
      cyc(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, c2, 1'b0);
      rd(16'hFE00); chk("R5 flag stays", rd_v, 16'h8000);
      rd(16'hFE02); chk("R5 overwritten char", rd_v, {8'h00, c2});
      rd(16'hFE00); chk("R4 flag cleared", rd_v, 16'h0000);
    end

    // R6 writes to keyboard registers ignored
    cyc(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 8'h33, 1'b0);
    cyc(16'hFE02, 1'b0, 1'b1, 16'hFFFF, 1'b0, 8'h0, 1'b0);
    cyc(16'hFE00, 1'b0, 1'b1, 16'h0000, 1'b0, 8'h0, 1'b0);
    rd(16'hFE00); chk("R6 flag kept", rd_v, 16'h8000);
    rd(16'hFE02); chk("R6 char kept", rd_v, 16'h0033);

    // R11 no read strobe gives zero
    cyc(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 8'h77, 1'b0);
    cyc(16'hFE00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0, 1'b0);
    chk("R11 idle rdata", rd_v, 16'h0000);
    cyc(16'hFE02, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0, 1'b0);
    chk("R11 idle rdata data", rd_v, 16'h0000);
    rd(16'hFE02); chk("R11 same-cycle read", rd_v, 16'h0077);

    // R7 / R8 sweep over all characters
    for (int c = 0; c < 256; c++) begin
      cyc(16'hFE06, 1'b0, 1'b1, {8'hC3, 8'(c)}, 1'b0, 8'h0, 1'b0);
      chk("R7 dsp_valid", {15'h0, dsp_valid}, 16'h1);
      chk("R7 dsp_char", {8'h0, dsp_char}, {8'h0, 8'(c)});
      rd(16'hFE04); chk("R7 status clear", rd_v, 16'h0000);
      rd(16'hFE06); chk("R10 ddata reads zero", rd_v, 16'h0000);
      cyc(16'h0, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0, 1'b1);
      chk("R8 dsp_valid low", {15'h0, dsp_valid}, 16'h0);
      rd(16'hFE04); chk("R8 status set", rd_v, 16'h8000);
    end

    // R9 same-cycle priority, keyboard
    cyc(16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 8'h11, 1'b0);
    cyc(16'hFE02, 1'b1, 1'b0, 16'h0, 1'b1, 8'h22, 1'b0);
    chk("R9 kbd read returns old", rd_v, 16'h0011);
    rd(16'hFE00); chk("R9 kbd set wins", rd_v, 16'h8000);
    rd(16'hFE02); chk("R9 kbd new char", rd_v, 16'h0022);

    // R9 same-cycle priority, display
    cyc(16'hFE06, 1'b0, 1'b1, 16'h0044, 1'b0, 8'h0, 1'b0);
    cyc(16'hFE06, 1'b0, 1'b1, 16'h0055, 1'b0, 8'h0, 1'b1);
    chk("R9 dsp set wins", {15'h0, dsp_valid}, 16'h0);
    chk("R9 dsp char stored", {8'h0, dsp_char}, 16'h0055);
    rd(16'hFE04); chk("R9 dsp status", rd_v, 16'h8000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule